// File: doc/BRIEF.md
# Page-Buffered Write Controller

This block is the device-side control logic of a byte-wide nonvolatile memory model. It watches three active-low bus strobes (chip select, output enable, write strobe) and decides each cycle whether the bus is reading, writing or idle. Each write pulse that is long enough places one byte into a 32-entry page latch. A load timer restarts at the end of every accepted pulse. When the bus stays quiet until the timer runs out, one self-timed program phase copies every loaded byte of the page into the cell array in a single step.

A host sees progress on a single `ready` line. It drops shortly after a write pulse begins and rises again once the program phase is over. Writes are refused for a set time after reset, and during the program phase. Reads issued while `ready` is low return the byte most recently loaded, not array contents. The cell array is a plain register array. All time windows are counted in clock cycles and set by parameters.

Top module: `ee_page_writer`

## Requirements
- R1: The bus mode comes from the strobes. Chip select low, output enable low and write strobe high is a read. Chip select low, write strobe low and output enable high is a write. Chip select high is standby. With chip select low and both other strobes low, nothing is written and `ready` stays high.
- R2: The upper ADDR_W-5 address bits pick the page (row). The lower 5 bits pick the byte slot within the 32-entry page latch.
- R3: A write pulse lasts while the write mode holds, so either the write strobe or chip select may end it. The address is captured on the first cycle of the pulse and the data on its last cycle.
- R4: A write pulse that holds for fewer than MIN_PULSE clock cycles loads nothing.
- R5: Programming starts LOAD_TMO cycles after the last accepted pulse ends. A new pulse that starts before then freezes the timer, and its acceptance restarts the timer. From the cycle a single pulse ends to `ready` going high takes 1+LOAD_TMO+PROG_CYC cycles.
- R6: The program phase lasts PROG_CYC cycles. It then writes every loaded byte of the page at once. Bytes not loaded keep their old contents, and the load mask is emptied.
- R7: `ready` is high after reset. It goes low from the cycle after an eligible write pulse begins until the program phase ends, and it is low whenever any byte is loaded.
- R8: For PWRUP_CYC cycles after reset is released, write pulses are ignored, `ready` stays high, and array contents survive the reset.
- R9: Write pulses that begin during the program phase are ignored.
- R10: If a byte is loaded to a page other than the one already held, the held bytes are dropped and the latch restarts on the new page with that byte alone.
- R11: A read while `ready` is low returns the most recently loaded byte.
- R12: `dout` and `dout_oe` are registered. A read request is answered one clock later, with `dout_oe` high. `dout_oe` is low one clock after any non-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | High when `dout` answers a read |
| ready | output | 1 | High when idle, low while loading or programming |

## Verification
The bench builds the block with an 8-bit address (eight 32-byte pages), MIN_PULSE of 3, LOAD_TMO of 16, PROG_CYC of 40 and PWRUP_CYC of 60. These short windows let it time the whole load-and-program sequence to the exact cycle. They also let it land a second pulse one cycle before the load timer would expire, and drop a pulse into the middle of a program phase. The small array lets it cross a page boundary for the rebase case, and repeat a reset without losing the array contents.

// File: rtl/ee_pw_pkg.sv
package ee_pw_pkg;

  // Decoded strobe combination seen on the bus this cycle
  typedef enum logic [1:0] {
    BUS_STBY  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_HOLD  = 2'd3
  } bus_mode_e;

  // Write sequencer phases
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_PROG = 2'd2
  } seq_state_e;

endpackage

// File: rtl/ee_rst_sync.sv
module ee_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ee_bus_decode.sv
module ee_bus_decode
  import ee_pw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output bus_mode_e         mode,
  output logic              wr_act,
  output logic              pulse_start,
  output logic              pulse_end,
  output logic              pulse_ok,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);

  logic              act_q;
  logic [CNT_W-1:0]  wid_q, wid_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  // strobe decode
  always_comb begin
    if (ce_n)               mode = BUS_STBY;
    else if (!oe_n && we_n) mode = BUS_READ;
    else if (oe_n && !we_n) mode = BUS_WRITE;
    else                    mode = BUS_HOLD;
  end

  assign wr_act      = (mode == BUS_WRITE);
  assign pulse_start = wr_act && !act_q;
  assign pulse_end   = !wr_act && act_q;
  assign pulse_ok    = pulse_end && (wid_q >= MIN_C);

  // width counter saturates at the minimum, address taken on the first
  // active cycle, data follows the bus until the last active cycle
  always_comb begin
    wid_d = '0;
    if (wr_act) begin
      if (!act_q)            wid_d = CNT_W'(1);
      else if (wid_q == MIN_C) wid_d = wid_q;
      else                   wid_d = wid_q + CNT_W'(1);
    end
    adr_d = pulse_start ? addr : adr_q;
    dat_d = wr_act ? din : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wid_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
    end else begin
      act_q <= wr_act;
      wid_q <= wid_d;
      adr_q <= adr_d;
      dat_q <= dat_d;
    end
  end

  assign wr_addr = adr_q;
  assign wr_data = dat_q;

endmodule

// File: rtl/ee_write_seq.sv
module ee_write_seq
  import ee_pw_pkg::*;
#(
  parameter int LOAD_TMO  = 5000,
  parameter int PROG_CYC  = 250000,
  parameter int PWRUP_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_act,
  input  logic       pulse_start,
  input  logic       pulse_end,
  input  logic       pulse_ok,
  output logic       load_en,
  output logic       commit,
  output logic       ready,
  output logic       inhibit,
  output seq_state_e state
);

  localparam int LT_W = $clog2(LOAD_TMO + 1);
  localparam int PC_W = $clog2(PROG_CYC + 1);
  localparam int PW_W = $clog2(PWRUP_CYC + 1);
  localparam logic [LT_W-1:0] LT_LAST = LT_W'(LOAD_TMO - 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_CYC - 1);
  localparam logic [PW_W-1:0] PW_END  = PW_W'(PWRUP_CYC);

  seq_state_e      st_q, st_d;
  logic            arm_q, arm_d;
  logic [LT_W-1:0] lt_q, lt_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PW_W-1:0] pw_q, pw_d;

  assign inhibit = (pw_q != PW_END);
  assign load_en = pulse_ok && arm_q;

  // power-up window and pulse eligibility
  always_comb begin
    pw_d = inhibit ? pw_q + PW_W'(1) : pw_q;
    arm_d = arm_q;
    if (pulse_start)    arm_d = !inhibit && (st_q != SEQ_PROG);
    else if (pulse_end) arm_d = 1'b0;
  end

  // phase sequencing with load timer and program counter
  always_comb begin
    st_d   = st_q;
    lt_d   = lt_q;
    pc_d   = pc_q;
    commit = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (load_en) begin
          st_d = SEQ_LOAD;
          lt_d = '0;
        end
      end
      SEQ_LOAD: begin
        if (load_en) begin
          lt_d = '0;
        end else if (wr_act) begin
          lt_d = lt_q;
        end else if (lt_q == LT_LAST) begin
          st_d = SEQ_PROG;
          pc_d = '0;
        end else begin
          lt_d = lt_q + LT_W'(1);
        end
      end
      SEQ_PROG: begin
        if (pc_q == PC_LAST) begin
          commit = 1'b1;
          st_d   = SEQ_IDLE;
        end else begin
          pc_d = pc_q + PC_W'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      arm_q <= 1'b0;
      lt_q  <= '0;
      pc_q  <= '0;
      pw_q  <= '0;
    end else begin
      st_q  <= st_d;
      arm_q <= arm_d;
      lt_q  <= lt_d;
      pc_q  <= pc_d;
      pw_q  <= pw_d;
    end
  end

  assign ready = (st_q == SEQ_IDLE) && !arm_q;
  assign state = st_q;

endmodule

// File: rtl/ee_page_latch.sv
module ee_page_latch #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int PAGE_AW = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_en,
  input  logic                                   commit,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [DATA_W-1:0]                      wr_data,
  output logic [ADDR_W-PAGE_AW-1:0]              row,
  output logic [(1<<PAGE_AW)-1:0]                mask,
  output logic [(1<<PAGE_AW)-1:0][DATA_W-1:0]    pg_data,
  output logic [DATA_W-1:0]                      last_byte
);

  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int ROW_W      = ADDR_W - PAGE_AW;

  logic [ROW_W-1:0]      row_q, row_d;
  logic [PAGE_BYTES-1:0] msk_q, msk_d;
  logic [DATA_W-1:0]     lst_q, lst_d;
  logic [ROW_W-1:0]      row_in;
  logic [PAGE_AW-1:0]    col_in;
  logic                  same_row;
  logic [PAGE_BYTES-1:0] ld_sel;

  assign row_in   = wr_addr[ADDR_W-1:PAGE_AW];
  assign col_in   = wr_addr[PAGE_AW-1:0];
  assign same_row = (msk_q == '0) || (row_in == row_q);

  always_comb begin
    row_d = row_q;
    msk_d = msk_q;
    lst_d = lst_q;
    if (commit) begin
      msk_d = '0;
    end else if (load_en) begin
      row_d = row_in;
      lst_d = wr_data;
      if (!same_row) msk_d = '0;
      msk_d[col_in] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      msk_q <= '0;
      lst_q <= '0;
    end else begin
      row_q <= row_d;
      msk_q <= msk_d;
      lst_q <= lst_d;
    end
  end

  // one data register per byte slot, enabled by its own load select
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    assign ld_sel[b] = load_en && (col_in == PAGE_AW'(b));
    always_ff @(posedge clk) begin
      if (ld_sel[b]) byte_q <= wr_data;
    end
    assign pg_data[b] = byte_q;
  end

  assign row       = row_q;
  assign mask      = msk_q;
  assign last_byte = lst_q;

endmodule

// File: rtl/ee_cell_array.sv
module ee_cell_array #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int PAGE_AW = 5
) (
  input  logic                                clk,
  input  logic                                commit,
  input  logic [ADDR_W-PAGE_AW-1:0]           row,
  input  logic [(1<<PAGE_AW)-1:0]             mask,
  input  logic [(1<<PAGE_AW)-1:0][DATA_W-1:0] pg_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // the whole page lands in one clock, gated per byte by the mask
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (mask[b]) mem[{row, PAGE_AW'(b)}] <= pg_data[b];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_page_writer.sv
module ee_page_writer
  import ee_pw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_AW   = 5,
  parameter int MIN_PULSE = 2,
  parameter int LOAD_TMO  = 5000,
  parameter int PROG_CYC  = 250000,
  parameter int PWRUP_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              ready
);

  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int ROW_W      = ADDR_W - PAGE_AW;

  logic                                srst_n;
  bus_mode_e                           bus_mode;
  logic                                wr_act, pulse_start, pulse_end, pulse_ok;
  logic [ADDR_W-1:0]                   wr_addr;
  logic [DATA_W-1:0]                   wr_data;
  logic                                load_en, commit, inhibit;
  seq_state_e                          seq_state;
  logic [ROW_W-1:0]                    pg_row;
  logic [PAGE_BYTES-1:0]               pg_mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]   pg_data;
  logic [DATA_W-1:0]                   last_byte;
  logic [DATA_W-1:0]                   arr_rd;
  logic                                rd_mode;
  logic [DATA_W-1:0]                   dout_q, dout_d;
  logic                                oe_q;

  ee_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ee_bus_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MIN_PULSE (MIN_PULSE)
  ) u_dec (
    .clk         (clk),
    .rst_n       (srst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .addr        (addr),
    .din         (din),
    .mode        (bus_mode),
    .wr_act      (wr_act),
    .pulse_start (pulse_start),
    .pulse_end   (pulse_end),
    .pulse_ok    (pulse_ok),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  ee_write_seq #(
    .LOAD_TMO  (LOAD_TMO),
    .PROG_CYC  (PROG_CYC),
    .PWRUP_CYC (PWRUP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_act      (wr_act),
    .pulse_start (pulse_start),
    .pulse_end   (pulse_end),
    .pulse_ok    (pulse_ok),
    .load_en     (load_en),
    .commit      (commit),
    .ready       (ready),
    .inhibit     (inhibit),
    .state       (seq_state)
  );

  ee_page_latch #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PAGE_AW (PAGE_AW)
  ) u_latch (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_en   (load_en),
    .commit    (commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .row       (pg_row),
    .mask      (pg_mask),
    .pg_data   (pg_data),
    .last_byte (last_byte)
  );

  ee_cell_array #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PAGE_AW (PAGE_AW)
  ) u_array (
    .clk     (clk),
    .commit  (commit),
    .row     (pg_row),
    .mask    (pg_mask),
    .pg_data (pg_data),
    .rd_addr (addr),
    .rd_data (arr_rd)
  );

  // read path: array contents when idle, last loaded byte when busy
  assign rd_mode = (bus_mode == BUS_READ);
  assign dout_d  = ready ? arr_rd : last_byte;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (rd_mode) dout_q <= dout_d;
      oe_q <= rd_mode;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

endmodule

// File: rtl/ee_page_writer_chk.sv
module ee_page_writer_chk
  import ee_pw_pkg::*;
#(
  parameter int MASK_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              load_en,
  input logic              commit,
  input logic              inhibit,
  input logic              dout_oe,
  input logic [MASK_W-1:0] mask,
  input seq_state_e        state,
  input bus_mode_e         mode
);

  // R6
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (mask == '0));

  // R7
  busy_with_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '0) |-> !ready);

  // R8
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> ready);

  // R5
  prog_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_PROG) && ($past(state) != SEQ_PROG)) |-> (mask != '0));

  // R9
  no_load_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_PROG) |-> !load_en);

  // R12
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_READ) |=> dout_oe);

endmodule

bind ee_page_writer ee_page_writer_chk #(.MASK_W(1 << PAGE_AW)) i_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .ready   (ready),
  .load_en (load_en),
  .commit  (commit),
  .inhibit (inhibit),
  .dout_oe (dout_oe),
  .mask    (pg_mask),
  .state   (seq_state),
  .mode    (bus_mode)
);

// File: tb/test_ee_page_writer.sv
module test_ee_page_writer;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int MP  = 3;
  localparam int LT  = 16;
  localparam int PC  = 40;
  localparam int PW  = 60;
  localparam int SEQ_LEN = 1 + LT + PC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe;
  logic          ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit rdy_in_pulse;

  always #10 clk = ~clk;

  ee_page_writer #(
    .ADDR_W (AW), .DATA_W (DW), .PAGE_AW (5), .MIN_PULSE (MP),
    .LOAD_TMO (LT), .PROG_CYC (PC), .PWRUP_CYC (PW)
  ) i_ee_page_writer (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .addr (addr), .din (din), .dout (dout), .dout_oe (dout_oe), .ready (ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_pulse(input logic [7:0] a, input logic [7:0] d,
                             input int width, input bit ce_ctl);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1;
    if (ce_ctl) begin
      we_n = 1'b0; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
    end else begin
      ce_n = 1'b0; we_n = 1'b0;
    end
    for (int i = 0; i < width; i++) begin
      @(negedge clk);
      if (i == 0) rdy_in_pulse = ready;
    end
    if (ce_ctl) begin
      ce_n = 1'b1;
      @(negedge clk);
      we_n = 1'b1;
    end else begin
      we_n = 1'b1; ce_n = 1'b1;
    end
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    d = dout; oe = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready && cyc < 5000);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic       oe;
    read_byte(a, d, oe);
    check(req, {31'd0, oe}, 32'd1);
    check(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // reset state: idle, no read answer
  task automatic t_reset_state();
    check("R7 ready after reset", {31'd0, ready}, 32'd1);
    check("R12 dout_oe after reset", {31'd0, dout_oe}, 32'd0);
  endtask

  // single byte: busy timing, readback, read latency and standby
  task automatic t_single();
    int cyc;
    write_pulse(8'h23, 8'hA5, MP, 1'b0);
    check("R7 ready low during pulse", {31'd0, rdy_in_pulse}, 32'd0);
    wait_ready(cyc);
    check("R5 R6 load plus program length", cyc, SEQ_LEN);
    expect_byte("R3 R12 single byte readback", 8'h23, 8'hA5);
    @(negedge clk);
    check("R1 standby drops dout_oe", {31'd0, dout_oe}, 32'd0);
  endtask

  // multi-byte page, then partial rewrite keeps untouched slots
  task automatic t_page();
    int cyc;
    write_pulse(8'h40, 8'h10, MP, 1'b0);
    write_pulse(8'h41, 8'h11, MP, 1'b0);
    write_pulse(8'h42, 8'h12, MP + 2, 1'b0);
    wait_ready(cyc);
    check("R6 page committed once", cyc, SEQ_LEN);
    write_pulse(8'h41, 8'h99, MP, 1'b0);
    wait_ready(cyc);
    expect_byte("R6 unloaded slot 0 kept", 8'h40, 8'h10);
    expect_byte("R2 slot 1 rewritten", 8'h41, 8'h99);
    expect_byte("R6 unloaded slot 2 kept", 8'h42, 8'h12);
  endtask

  // second pulse one cycle before expiry restarts the timer
  task automatic t_timer_restart();
    int cyc;
    write_pulse(8'h24, 8'h31, MP, 1'b0);
    repeat (LT - 2) @(negedge clk);
    check("R5 still loading before expiry", {31'd0, ready}, 32'd0);
    write_pulse(8'h25, 8'h32, MP, 1'b0);
    wait_ready(cyc);
    check("R5 timer restarted by late pulse", cyc, SEQ_LEN);
    expect_byte("R5 first byte kept", 8'h24, 8'h31);
    expect_byte("R5 late byte committed", 8'h25, 8'h32);
  endtask

  // short pulse is discarded
  task automatic t_glitch();
    write_pulse(8'h40, 8'hEE, MP - 1, 1'b0);
    @(negedge clk);
    check("R4 short pulse leaves ready high", {31'd0, ready}, 32'd1);
    expect_byte("R4 short pulse wrote nothing", 8'h40, 8'h10);
  endtask

  // output enable low with write strobe low is not a write
  task automatic t_oe_block();
    @(negedge clk);
    addr = 8'h40; din = 8'h77; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (MP + 2) @(negedge clk);
    check("R1 both strobes low keeps ready", {31'd0, ready}, 32'd1);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no busy after blocked write", {31'd0, ready}, 32'd1);
    expect_byte("R1 blocked write left data", 8'h40, 8'h10);
  endtask

  // chip-select controlled pulse
  task automatic t_ce_write();
    int cyc;
    write_pulse(8'h05, 8'h3C, MP, 1'b1);
    wait_ready(cyc);
    expect_byte("R3 chip select write", 8'h05, 8'h3C);
  endtask

  // reads while loading return the last loaded byte
  task automatic t_busy_read();
    int cyc;
    write_pulse(8'h30, 8'h6B, MP, 1'b0);
    expect_byte("R11 busy read returns latched", 8'h40, 8'h6B);
    wait_ready(cyc);
    expect_byte("R11 array after busy", 8'h30, 8'h6B);
    expect_byte("R11 idle read returns array", 8'h40, 8'h10);
  endtask

  // pulse during program phase is ignored
  task automatic t_prog_ignore();
    int cyc;
    write_pulse(8'h50, 8'h55, MP, 1'b0);
    repeat (LT + 3) @(negedge clk);
    write_pulse(8'h41, 8'hAA, MP + 1, 1'b0);
    check("R9 busy during program", {31'd0, rdy_in_pulse}, 32'd0);
    wait_ready(cyc);
    @(negedge clk);
    check("R9 no second program", {31'd0, ready}, 32'd1);
    expect_byte("R9 first byte written", 8'h50, 8'h55);
    expect_byte("R9 ignored pulse", 8'h41, 8'h99);
  endtask

  // load to another page rebases the latch
  task automatic t_rebase();
    int cyc;
    write_pulse(8'h42, 8'hC1, MP, 1'b0);
    write_pulse(8'h60, 8'hC2, MP, 1'b0);
    wait_ready(cyc);
    check("R10 single program after rebase", cyc, SEQ_LEN);
    expect_byte("R10 dropped old page byte", 8'h42, 8'h12);
    expect_byte("R10 new page byte", 8'h60, 8'hC2);
  endtask

  // writes refused right after reset, array survives reset
  task automatic t_powerup();
    do_reset();
    check("R8 ready after second reset", {31'd0, ready}, 32'd1);
    write_pulse(8'h23, 8'h00, MP + 1, 1'b0);
    check("R8 no busy in power-up window", {31'd0, rdy_in_pulse}, 32'd1);
    @(negedge clk);
    check("R8 ready stays high", {31'd0, ready}, 32'd1);
    repeat (PW + 10) @(negedge clk);
    expect_byte("R8 inhibited write dropped", 8'h23, 8'hA5);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    repeat (PW + 10) @(negedge clk);
    t_single();
    t_page();
    t_timer_restart();
    t_glitch();
    t_oe_block();
    t_ce_write();
    t_busy_read();
    t_prog_ignore();
    t_rebase();
    t_powerup();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule